// File: doc/BRIEF.md
# Windowed FIFO Transfer Sequencer

This block moves a software-programmed number of bytes between a 512-byte byte-wide FIFO and a card-side data port. The host side is a simple word bus. One control word sets the byte count, the direction, the card beat width and a few mode flags, and a start bit launches the move. Host data goes in through a write aperture and comes out through a read aperture. Every word address inside an aperture reaches the FIFO.

The sequencer paces an external DMA engine one window at a time. It pulses a buffer-available event when a whole window of data can be read out. In the other direction it pulses the same event when a whole window of free space can be filled. The last window may be shorter than 512 bytes. A done pulse marks the point where every byte has passed both sides. An error pulse reports a misdirected or impossible aperture access, or a transfer error signalled from the card side.

Clearing the start bit aborts the move immediately. An error does the same. In both cases the FIFO is emptied and the counters are cleared on the same clock edge.

Top module: `cfx_xfer_seq`

## Requirements
- R1: The control word is at byte offset 0x000 and has these fields: count in bits [17:0], address-increment disable in bit 24, card width in bit 25 (0 = 8-bit, 1 = 16-bit), attribute select in bit 26, I/O select in bit 27, DMA mode in bit 28, direction in bit 30 (0 = card to host, 1 = host to card) and start in bit 31. A read of the control word returns the stored flags. In that readback, bit 31 shows whether a transfer is running and bits [17:0] show the card-side bytes still to move. After reset the control word reads as zero.
- R2: A count above 0x20000 written together with start is loaded as 0x20000.
- R3: In card-to-host mode, card bytes enter the FIFO in arrival order. A read of any word in 0x400–0x5FF returns up to four bytes, the oldest byte in bits [7:0]. Lanes past the end of the count read as zero.
- R4: In host-to-card mode, a word written anywhere in 0x200–0x3FF supplies up to four bytes, bits [7:0] first. The card port sends them out in order. An 8-bit beat uses data[7:0] with data[15:8] at zero. A 16-bit beat sends the older byte in [7:0].
- R5: Each card beat moves one byte in 8-bit mode and two bytes in 16-bit mode. When a single byte remains in 16-bit mode, the beat moves only that byte, with the upper byte at zero on output. Exactly the programmed count crosses the card port.
- R6: Buffer-available is a one-cycle pulse. In card-to-host mode it fires when min(512, bytes the host still has to read) bytes are buffered. In host-to-card mode it fires when that much space is free. It does not fire again until the host has moved that whole window, so a count of N gives ceil(N/512) pulses.
- R7: Done is a one-cycle pulse that fires once both sides have moved the full count. The start bit clears at the same time. A count of zero gives a done pulse and no buffer-available pulse.
- R8: Writing the control word with bit 31 at zero stops a running transfer on that clock edge. The FIFO is flushed, the remaining count reads zero, the card handshake drops, and no done pulse follows. A later transfer sees none of the old data.
- R9: A transfer-error input pulse raises the error event one cycle later and aborts the transfer as in R8.
- R10: An aperture access is an error and aborts the transfer in these cases: the wrong aperture for the programmed direction, a write to the read aperture, a read from the write aperture, or any aperture access while idle.
- R11: Writing when the FIFO lacks room for the word's bytes (overflow) is an error that aborts the transfer. Reading when fewer bytes are buffered than the word needs (underflow) is the same kind of error. The offending access moves no data and reads zero.
- R12: The card read handshake is ready only when a transfer is running card-to-host and there is room for a full beat. The card write handshake is valid only when a transfer is running host-to-card and a full beat is buffered. Both are low while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Host access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | 12 | Host byte address |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, valid in the access cycle |
| card_rd_valid | input | 1 | Card offers a beat (card to host) |
| card_rd_data | input | 16 | Card beat data (card to host) |
| card_rd_ready | output | 1 | Sequencer accepts the offered beat |
| card_wr_valid | output | 1 | Sequencer offers a beat (host to card) |
| card_wr_data | output | 16 | Beat data toward the card |
| card_wr_ready | input | 1 | Card takes the offered beat |
| pio_err | input | 1 | Card-side transfer error |
| evt_buf_avail | output | 1 | Window ready pulse |
| evt_done | output | 1 | Transfer complete pulse |
| evt_err | output | 1 | Transfer error pulse |

## Verification
If the window counter gets out of step with the host, buffer-available stops firing or fires a second time. The bench counts those pulses and catches this within one window. An error in the remaining count or the beat step shows up in three places: the count readback, the number of card beats taken, and whether done arrives at the right point. Done may arrive too early, too late or not at all, so the bench sees this by the end of the transfer. A FIFO that is not flushed on abort returns stale bytes on the first read of the next transfer. A misjudged direction or level check shows up as a missing or spurious error pulse one cycle after the access.

// File: rtl/cfx_pkg.sv
// Shared address map, control-word bit positions and config type for the
// windowed transfer sequencer.
package cfx_pkg;

    // Host address map (byte offsets); apertures are decoded by high bits.
    localparam int unsigned CTRL_OFS    = 32'h000;
    localparam int unsigned WWIN_BASE   = 32'h200;
    localparam int unsigned RWIN_BASE   = 32'h400;
    localparam int unsigned WIN_SPAN_SH = 9;

    // Control word bit positions decoded by software.
    localparam int unsigned B_INC_OFF = 24;
    localparam int unsigned B_WIDE    = 25;
    localparam int unsigned B_ATTR    = 26;
    localparam int unsigned B_IO      = 27;
    localparam int unsigned B_DMA     = 28;
    localparam int unsigned B_DIR     = 30;
    localparam int unsigned B_START   = 31;

    // Stored transfer options.
    typedef struct packed {
        logic dir_wr;
        logic dma_mode;
        logic io_sel;
        logic attr_sel;
        logic wide;
        logic inc_off;
    } xfer_cfg_t;

endpackage

// File: rtl/cfx_byte_ring.sv
// Byte-wide circular FIFO that accepts up to LANES bytes pushed and up to
// LANES bytes popped per cycle. Assumes DEPTH is a power of two and that
// callers never push beyond free space or pop beyond the level.
module cfx_byte_ring #(
    parameter int unsigned DEPTH = 512,
    parameter int unsigned LANES = 4,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned LVL_W = $clog2(DEPTH + 1),
    localparam int unsigned N_W   = $clog2(LANES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic [N_W-1:0]       push_n,
    input  logic [LANES*8-1:0]   push_data,
    input  logic [N_W-1:0]       pop_n,
    output logic [LANES*8-1:0]   head,
    output logic [LVL_W-1:0]     level,
    output logic [LVL_W-1:0]     free
);

    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    // Byte lanes are written at consecutive ring positions.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (!flush && (N_W'(i) < push_n)) begin
                mem[wr_ptr + PTR_W'(i)] <= push_data[i*8 +: 8];
            end
        end
    end

    // Pointer and occupancy tracking, cleared by reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            wr_ptr <= wr_ptr + PTR_W'(push_n);
            rd_ptr <= rd_ptr + PTR_W'(pop_n);
            level  <= level + LVL_W'(push_n) - LVL_W'(pop_n);
        end
    end

    // Oldest bytes presented lane by lane.
    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_head
            assign head[g*8 +: 8] = mem[rd_ptr + PTR_W'(g)];
        end
    endgenerate

    // Space left for pushes.
    assign free = LVL_W'(DEPTH) - level;

endmodule

// File: rtl/cfx_window_count.sv
// Remaining-count and window bookkeeping. Tracks bytes owed on the card side
// and on the host side separately, announces each window once, and flags
// completion when both sides are exhausted. Assumes load and clear are never
// asserted together.
module cfx_window_count #(
    parameter int unsigned CNT_W = 18,
    parameter int unsigned WIN   = 512,
    parameter int unsigned LANES = 4,
    parameter int unsigned LVL_W = 10,
    localparam int unsigned N_W  = $clog2(LANES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_cnt,
    input  logic             clear,
    input  logic             active,
    input  logic             dir_wr,
    input  logic             wide,
    input  logic             card_fire,
    input  logic             host_fire,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] free,
    output logic [1:0]       card_bytes,
    output logic [N_W-1:0]   host_bytes,
    output logic [CNT_W-1:0] card_left,
    output logic             done_cond,
    output logic             evt_buf_avail
);

    logic [CNT_W-1:0] host_left;
    logic [LVL_W-1:0] win_left;
    logic [LVL_W-1:0] need;
    logic             win_ready;

    // Bytes moved by the next card beat or host word.
    always_comb begin
        if (card_left == '0)
            card_bytes = 2'd0;
        else if (wide && (card_left >= CNT_W'(2)))
            card_bytes = 2'd2;
        else
            card_bytes = 2'd1;
        host_bytes = (host_left >= CNT_W'(LANES)) ? N_W'(LANES) : N_W'(host_left);
    end

    // Size of the next window and whether the FIFO can serve it now.
    always_comb begin
        need      = (host_left >= CNT_W'(WIN)) ? LVL_W'(WIN) : LVL_W'(host_left);
        win_ready = active && (win_left == '0) && (host_left != '0) && !host_fire &&
                    (dir_wr ? (free >= need) : (level >= need));
        done_cond = active && (card_left == '0) && (host_left == '0);
    end

    // Counter updates: clear, load, then per-side decrements.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            card_left <= '0;
            host_left <= '0;
            win_left  <= '0;
        end else if (load) begin
            card_left <= load_cnt;
            host_left <= load_cnt;
            win_left  <= '0;
        end else begin
            if (card_fire)
                card_left <= card_left - CNT_W'(card_bytes);
            if (host_fire) begin
                host_left <= host_left - CNT_W'(host_bytes);
                win_left  <= (win_left > LVL_W'(host_bytes)) ?
                             (win_left - LVL_W'(host_bytes)) : '0;
            end else if (win_ready) begin
                win_left <= need;
            end
        end
    end

    // One-cycle window announcement.
    always_ff @(posedge clk) begin
        if (!rst_n)
            evt_buf_avail <= 1'b0;
        else
            evt_buf_avail <= win_ready && !clear && !load;
    end

endmodule

// File: rtl/cfx_ctrl_port.sv
// Host access decode: control word, data apertures, access checks, the
// running flag and the done and error events. Assumes one access per
// bus_valid cycle with read data taken in that same cycle.
module cfx_ctrl_port
    import cfx_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned CNT_W     = 18,
    parameter int unsigned MAX_COUNT = 32'h20000,
    parameter int unsigned LANES     = 4,
    parameter int unsigned LVL_W     = 10,
    localparam int unsigned N_W      = $clog2(LANES + 1),
    localparam int unsigned BUS_W    = LANES * 8,
    localparam int unsigned HI_W     = ADDR_W - WIN_SPAN_SH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             pio_err,
    input  logic             done_cond,
    input  logic [CNT_W-1:0] card_left,
    input  logic [N_W-1:0]   host_bytes,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] free,
    input  logic [BUS_W-1:0] head,
    output logic             active,
    output xfer_cfg_t        cfg,
    output logic             load,
    output logic [CNT_W-1:0] load_cnt,
    output logic             clear,
    output logic             host_fire,
    output logic             evt_done,
    output logic             evt_err
);

    logic hit_ctrl, hit_wwin, hit_rwin;
    logic ok_w, ok_r, ovf, udf, bad_win, err_cond;
    logic ctrl_wr, start_wr, stop_wr;
    logic [BUS_W-1:0] ctrl_view;
    logic [BUS_W-1:0] rd_word;
    logic unused_bits;

    assign unused_bits = ^{bus_wdata[23:CNT_W], bus_wdata[29]};

    // Address decode of the control word and both apertures.
    always_comb begin
        hit_ctrl = bus_valid && (bus_addr == ADDR_W'(CTRL_OFS));
        hit_wwin = bus_valid && (bus_addr[ADDR_W-1:WIN_SPAN_SH] == HI_W'(WWIN_BASE >> WIN_SPAN_SH));
        hit_rwin = bus_valid && (bus_addr[ADDR_W-1:WIN_SPAN_SH] == HI_W'(RWIN_BASE >> WIN_SPAN_SH));
    end

    // Legality of aperture accesses and the resulting error condition.
    always_comb begin
        ok_w     = hit_wwin && bus_write && active && cfg.dir_wr;
        ok_r     = hit_rwin && !bus_write && active && !cfg.dir_wr;
        bad_win  = (hit_wwin && !ok_w) || (hit_rwin && !ok_r);
        ovf      = ok_w && ((host_bytes == '0) || (free < LVL_W'(host_bytes)));
        udf      = ok_r && ((host_bytes == '0) || (level < LVL_W'(host_bytes)));
        err_cond = bad_win || ovf || udf || pio_err;
        host_fire = (ok_w && !ovf) || (ok_r && !udf);
    end

    // Control word writes: start loads, a cleared start aborts.
    always_comb begin
        ctrl_wr  = hit_ctrl && bus_write;
        start_wr = ctrl_wr && bus_wdata[B_START];
        stop_wr  = ctrl_wr && !bus_wdata[B_START];
        load     = start_wr && !err_cond;
        clear    = stop_wr || err_cond;
        load_cnt = (bus_wdata[CNT_W-1:0] > CNT_W'(MAX_COUNT)) ?
                   CNT_W'(MAX_COUNT) : bus_wdata[CNT_W-1:0];
    end

    // Stored options, updated on every control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (ctrl_wr) begin
            cfg.dir_wr   <= bus_wdata[B_DIR];
            cfg.dma_mode <= bus_wdata[B_DMA];
            cfg.io_sel   <= bus_wdata[B_IO];
            cfg.attr_sel <= bus_wdata[B_ATTR];
            cfg.wide     <= bus_wdata[B_WIDE];
            cfg.inc_off  <= bus_wdata[B_INC_OFF];
        end
    end

    // Running flag: set by load, cleared by abort, error or completion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active <= 1'b0;
        else if (load)
            active <= 1'b1;
        else if (clear || done_cond)
            active <= 1'b0;
    end

    // Registered one-cycle events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_done <= 1'b0;
            evt_err  <= 1'b0;
        end else begin
            evt_done <= done_cond && !clear;
            evt_err  <= err_cond;
        end
    end

    // Readback image of the control word.
    always_comb begin
        ctrl_view            = '0;
        ctrl_view[CNT_W-1:0] = card_left;
        ctrl_view[B_INC_OFF] = cfg.inc_off;
        ctrl_view[B_WIDE]    = cfg.wide;
        ctrl_view[B_ATTR]    = cfg.attr_sel;
        ctrl_view[B_IO]      = cfg.io_sel;
        ctrl_view[B_DMA]     = cfg.dma_mode;
        ctrl_view[B_DIR]     = cfg.dir_wr;
        ctrl_view[B_START]   = active;
    end

    // Aperture read word with lanes past the count forced to zero.
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < LANES; i++) begin
            if (N_W'(i) < host_bytes)
                rd_word[i*8 +: 8] = head[i*8 +: 8];
        end
    end

    // Read data mux.
    always_comb begin
        if (hit_ctrl && !bus_write)
            bus_rdata = ctrl_view;
        else if (ok_r && !udf)
            bus_rdata = rd_word;
        else
            bus_rdata = '0;
    end

endmodule

// File: rtl/cfx_xfer_seq.sv
// Top of the windowed transfer sequencer: joins host decode, window counter
// and byte FIFO, and runs the card-side beat handshake. Assumes a single
// clock domain and a card port that holds data while valid is high.
module cfx_xfer_seq
    import cfx_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned CNT_W     = 18,
    parameter int unsigned MAX_COUNT = 32'h20000,
    parameter int unsigned WIN_BYTES = 512,
    parameter int unsigned BUS_W     = 32,
    localparam int unsigned LANES    = BUS_W / 8,
    localparam int unsigned LVL_W    = $clog2(WIN_BYTES + 1),
    localparam int unsigned N_W      = $clog2(LANES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              card_rd_valid,
    input  logic [15:0]       card_rd_data,
    output logic              card_rd_ready,
    output logic              card_wr_valid,
    output logic [15:0]       card_wr_data,
    input  logic              card_wr_ready,
    input  logic              pio_err,
    output logic              evt_buf_avail,
    output logic              evt_done,
    output logic              evt_err
);

    xfer_cfg_t         cfg;
    logic              xfer_active;
    logic              load, clear, host_fire, done_cond, card_fire;
    logic [CNT_W-1:0]  load_cnt, card_left;
    logic [1:0]        card_bytes;
    logic [N_W-1:0]    host_bytes;
    logic [LVL_W-1:0]  fifo_level, fifo_free;
    logic [BUS_W-1:0]  fifo_head, push_data;
    logic [N_W-1:0]    push_n, pop_n;

    cfx_ctrl_port #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAX_COUNT(MAX_COUNT),
        .LANES(LANES), .LVL_W(LVL_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pio_err(pio_err),
        .done_cond(done_cond), .card_left(card_left), .host_bytes(host_bytes),
        .level(fifo_level), .free(fifo_free), .head(fifo_head),
        .active(xfer_active), .cfg(cfg), .load(load), .load_cnt(load_cnt),
        .clear(clear), .host_fire(host_fire),
        .evt_done(evt_done), .evt_err(evt_err)
    );

    cfx_window_count #(
        .CNT_W(CNT_W), .WIN(WIN_BYTES), .LANES(LANES), .LVL_W(LVL_W)
    ) u_count (
        .clk(clk), .rst_n(rst_n), .load(load), .load_cnt(load_cnt),
        .clear(clear), .active(xfer_active), .dir_wr(cfg.dir_wr),
        .wide(cfg.wide), .card_fire(card_fire), .host_fire(host_fire),
        .level(fifo_level), .free(fifo_free), .card_bytes(card_bytes),
        .host_bytes(host_bytes), .card_left(card_left),
        .done_cond(done_cond), .evt_buf_avail(evt_buf_avail)
    );

    cfx_byte_ring #(
        .DEPTH(WIN_BYTES), .LANES(LANES)
    ) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(clear),
        .push_n(push_n), .push_data(push_data), .pop_n(pop_n),
        .head(fifo_head), .level(fifo_level), .free(fifo_free)
    );

    // Card-side handshake: a beat is offered or accepted only when whole.
    always_comb begin
        card_rd_ready = xfer_active && !cfg.dir_wr && (card_left != '0) &&
                        (fifo_free >= LVL_W'(card_bytes));
        card_wr_valid = xfer_active && cfg.dir_wr && (card_left != '0) &&
                        (fifo_level >= LVL_W'(card_bytes));
        card_fire     = (card_rd_valid && card_rd_ready) ||
                        (card_wr_valid && card_wr_ready);
        card_wr_data  = (card_bytes == 2'd2) ? fifo_head[15:0] : {8'h00, fifo_head[7:0]};
    end

    // FIFO steering: the host fills and the card drains, or the reverse.
    always_comb begin
        if (cfg.dir_wr) begin
            push_data = bus_wdata;
            push_n    = host_fire ? host_bytes : '0;
            pop_n     = card_fire ? N_W'(card_bytes) : '0;
        end else begin
            push_data = {{(BUS_W-16){1'b0}}, card_rd_data};
            push_n    = card_fire ? N_W'(card_bytes) : '0;
            pop_n     = host_fire ? host_bytes : '0;
        end
    end

endmodule

// File: rtl/cfx_xfer_seq_chk.sv
// Property checker for the transfer sequencer, attached by bind. Observes
// ports plus the running flag and FIFO level.
module cfx_xfer_seq_chk
    import cfx_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DEPTH  = 512,
    parameter int unsigned LVL_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              start_bit,
    input logic              pio_err,
    input logic              card_rd_ready,
    input logic              card_wr_valid,
    input logic              evt_buf_avail,
    input logic              evt_done,
    input logic              evt_err,
    input logic              active,
    input logic [LVL_W-1:0]  level
);

    logic stop_req;
    assign stop_req = bus_valid && bus_write && (bus_addr == ADDR_W'(CTRL_OFS)) && !start_bit;

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        evt_done |=> !evt_done);

    a_r6_window_single: assert property (@(posedge clk) disable iff (!rst_n)
        evt_buf_avail |=> !evt_buf_avail);

    a_r8_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> (!active && !card_rd_ready && !card_wr_valid));

    a_r9_pio_err_event: assert property (@(posedge clk) disable iff (!rst_n)
        pio_err |=> (evt_err && !active));

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (!card_rd_ready && !card_wr_valid));

    a_r12_one_side: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({card_rd_ready, card_wr_valid}));

    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

endmodule

bind cfx_xfer_seq cfx_xfer_seq_chk #(
    .ADDR_W(ADDR_W), .DEPTH(WIN_BYTES), .LVL_W(LVL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .start_bit(bus_wdata[31]), .pio_err(pio_err),
    .card_rd_ready(card_rd_ready), .card_wr_valid(card_wr_valid),
    .evt_buf_avail(evt_buf_avail), .evt_done(evt_done), .evt_err(evt_err),
    .active(xfer_active), .level(fifo_level)
);

// File: tb/cfx_xfer_seq_bench.sv
`timescale 1ns/1ps
module cfx_xfer_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        card_rd_valid = 1'b0;
    logic [15:0] card_rd_data = '0;
    logic        card_rd_ready, card_wr_valid;
    logic [15:0] card_wr_data;
    logic        card_wr_ready = 1'b0;
    logic        pio_err = 1'b0;
    logic        evt_buf_avail, evt_done, evt_err;

    int tests = 0, fails = 0;
    int ba_cnt = 0, done_cnt = 0, err_cnt = 0;
    bit finished = 0;

    logic [7:0] data_q [4096];
    int  xfer_len = 0;
    bit  xfer_wr = 0, xfer_wide = 0;
    bit  card_en = 0;
    int  card_idx = 0;
    int  sink_bad = 0;

    always #2.5 clk = ~clk;

    cfx_xfer_seq u_cfx_xfer_seq (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .card_rd_valid(card_rd_valid), .card_rd_data(card_rd_data),
        .card_rd_ready(card_rd_ready), .card_wr_valid(card_wr_valid),
        .card_wr_data(card_wr_data), .card_wr_ready(card_wr_ready),
        .pio_err(pio_err), .evt_buf_avail(evt_buf_avail),
        .evt_done(evt_done), .evt_err(evt_err)
    );

    // Event counters, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (evt_buf_avail) ba_cnt++;
            if (evt_done)      done_cnt++;
            if (evt_err)       err_cnt++;
        end
    end

    function automatic int step_of(int idx);
        if (xfer_wide && (xfer_len - idx >= 2)) return 2;
        return 1;
    endfunction

    function automatic logic [15:0] beat_of(int idx);
        if (step_of(idx) == 2) return {data_q[idx+1], data_q[idx]};
        return {8'h00, data_q[idx]};
    endfunction

    function automatic logic [31:0] word_of(int pos, int nb);
        logic [31:0] w = '0;
        for (int i = 0; i < nb; i++) w[i*8 +: 8] = data_q[pos+i];
        return w;
    endfunction

    // Card model: source in card-to-host mode, checking sink otherwise.
    always @(negedge clk) begin
        if (card_en && !xfer_wr && card_idx < xfer_len) begin
            card_rd_valid = ($urandom_range(0, 3) != 0);
            card_rd_data  = xfer_wide ? {data_q[card_idx+1], data_q[card_idx]}
                                      : {8'h00, data_q[card_idx]};
            if (card_rd_valid && card_rd_ready) card_idx += step_of(card_idx);
        end else begin
            card_rd_valid = 1'b0;
        end
        if (card_en && xfer_wr) begin
            card_wr_ready = ($urandom_range(0, 3) != 0);
            if (card_wr_ready && card_wr_valid) begin
                if (card_idx >= xfer_len || card_wr_data != beat_of(card_idx)) sink_bad++;
                card_idx += step_of(card_idx);
            end
        end else begin
            card_wr_ready = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_wdata = '0;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(input bit wr, input bit wide, input int len);
        for (int i = 0; i < 4096; i++) data_q[i] = 8'($urandom);
        xfer_wr = wr; xfer_wide = wide; xfer_len = len;
        card_idx = 0; sink_bad = 0;
    endtask

    function automatic logic [31:0] ctrl_of(bit wr, bit wide, int len);
        return 32'h8000_0000 | (32'(wr) << 30) | 32'h1000_0000 | (32'(wide) << 25) | 32'(len);
    endfunction

    // Full transfer driven window by window, checked on data, counts, events.
    task automatic run_xfer(input bit wr, input bit wide, input int len);
        int left, pos, wins, bad, ba0, d0, e0, nb, t;
        logic [31:0] got, ctl;
        setup(wr, wide, len);
        ba0 = ba_cnt; d0 = done_cnt; e0 = err_cnt; bad = 0;
        ctl = ctrl_of(wr, wide, len);
        bus_wr(12'h000, ctl);
        card_en = 1;
        left = len; pos = 0; wins = 0;
        while (left > 0) begin
            t = 0;
            while (ba_cnt <= ba0 + wins && t < 20000) begin idle(1); t++; end
            if (t >= 20000) break;
            for (int k = 0; k < ((left > 512) ? 512 : left); k += 4) begin
                nb = (left - k >= 4) ? 4 : left - k;
                if (wr) bus_wr(12'h200 + 12'($urandom_range(0, 127) * 4), word_of(pos + k, nb));
                else begin
                    bus_rd(12'h400 + 12'($urandom_range(0, 127) * 4), got);
                    if (got != word_of(pos + k, nb)) bad++;
                end
            end
            pos  += (left > 512) ? 512 : left;
            left -= (left > 512) ? 512 : left;
            wins++;
        end
        t = 0;
        while (done_cnt == d0 && t < 5000) begin idle(1); t++; end
        card_en = 0;
        idle(2);
        chk(bad == 0 && sink_bad == 0, wr ? "R4 data order" : "R3 data order", 32'(bad + sink_bad), 0);
        chk(card_idx == len, "R5 card byte total", 32'(card_idx), 32'(len));
        chk(ba_cnt - ba0 == (len + 511) / 512, "R6 window pulses", 32'(ba_cnt - ba0), 32'((len + 511) / 512));
        chk(done_cnt - d0 == 1 && err_cnt == e0, "R7 single done", 32'(done_cnt - d0), 1);
        bus_rd(12'h000, got);
        chk(got == (ctl & 32'h7FFC_0000), "R1 readback after done", got, ctl & 32'h7FFC_0000);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog actual=expired expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] got;
        int e0, d0, b0, t;
        void'($urandom(32'd2718));
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        idle(2);

        bus_rd(12'h000, got);
        chk(got == 0, "R1 reset readback", got, 0);
        chk(!card_rd_ready && !card_wr_valid && ba_cnt == 0, "R12 idle handshake", {card_rd_ready, card_wr_valid}, 0);

        // Directed transfers covering widths, short final windows, one byte.
        run_xfer(0, 0, 1300);
        run_xfer(0, 1, 777);
        run_xfer(1, 0, 1025);
        run_xfer(1, 1, 513);
        run_xfer(0, 1, 1);
        run_xfer(1, 1, 3);

        // Zero count finishes at once without a window.
        b0 = ba_cnt; d0 = done_cnt;
        bus_wr(12'h000, 32'h8000_0000);
        idle(4);
        chk(done_cnt == d0 + 1 && ba_cnt == b0, "R7 zero count", 32'(done_cnt - d0), 1);

        // Count clamp.
        setup(0, 0, 4000);
        bus_wr(12'h000, 32'h8003_FFFF);
        bus_rd(12'h000, got);
        chk(got == 32'h8002_0000, "R2 count clamp", got, 32'h8002_0000);
        bus_wr(12'h000, 32'h0);

        // FIFO full in card-to-host mode stops the card handshake.
        setup(0, 0, 1024);
        b0 = ba_cnt;
        bus_wr(12'h000, ctrl_of(0, 0, 1024));
        card_en = 1;
        idle(1500);
        chk(!card_rd_ready && card_idx == 512, "R12 full stops card", 32'(card_idx), 512);
        chk(ba_cnt == b0 + 1, "R6 one pulse per window", 32'(ba_cnt - b0), 1);

        // Abort mid-transfer, then a fresh transfer must see new data only.
        card_en = 0;
        idle(1);
        d0 = done_cnt;
        bus_wr(12'h000, 32'h0);
        chk(!card_rd_ready && !card_wr_valid, "R8 handshake drops", {card_rd_ready, card_wr_valid}, 0);
        bus_rd(12'h000, got);
        chk(got == 0, "R8 count cleared", got, 0);
        idle(20);
        chk(done_cnt == d0, "R8 no done after abort", 32'(done_cnt - d0), 0);
        run_xfer(0, 0, 8);

        // Wrong aperture for direction.
        setup(0, 0, 64);
        e0 = err_cnt;
        bus_wr(12'h000, ctrl_of(0, 0, 64));
        bus_wr(12'h204, 32'h1234_5678);
        idle(2);
        bus_rd(12'h000, got);
        chk(err_cnt == e0 + 1 && got[31] == 0, "R10 wrong aperture", 32'(err_cnt - e0), 1);

        // Aperture access while idle.
        e0 = err_cnt;
        bus_rd(12'h404, got);
        idle(2);
        chk(err_cnt == e0 + 1 && got == 0, "R10 idle access", 32'(err_cnt - e0), 1);

        // Underflow on an empty FIFO.
        setup(0, 0, 100);
        e0 = err_cnt;
        bus_wr(12'h000, ctrl_of(0, 0, 100));
        bus_rd(12'h400, got);
        idle(2);
        chk(got == 0 && err_cnt == e0 + 1, "R11 underflow", got, 0);
        bus_rd(12'h000, got);
        chk(got[31] == 0, "R11 underflow aborts", got, 32'h0);

        // Overflow: fill a window with the card stalled, then one word more.
        setup(1, 0, 1024);
        b0 = ba_cnt; e0 = err_cnt;
        bus_wr(12'h000, ctrl_of(1, 0, 1024));
        t = 0;
        while (ba_cnt == b0 && t < 100) begin idle(1); t++; end
        for (int k = 0; k < 128; k++) bus_wr(12'h200 + 12'(k * 4), word_of(k * 4, 4));
        idle(1);
        chk(card_wr_valid && card_wr_data == {8'h00, data_q[0]}, "R12 write beat offered", {15'd0, card_wr_valid, card_wr_data}, {16'd1, 8'h00, data_q[0]});
        chk(err_cnt == e0, "R11 full window no error", 32'(err_cnt - e0), 0);
        bus_wr(12'h3FC, 32'hDEAD_BEEF);
        idle(2);
        bus_rd(12'h000, got);
        chk(err_cnt == e0 + 1 && got[31] == 0 && got[17:0] == 0, "R11 overflow aborts", got, 32'h0);

        // Card-side error input.
        setup(0, 0, 100);
        e0 = err_cnt;
        bus_wr(12'h000, ctrl_of(0, 0, 100));
        @(negedge clk); pio_err = 1'b1;
        @(negedge clk); pio_err = 1'b0;
        idle(2);
        bus_rd(12'h000, got);
        chk(err_cnt == e0 + 1 && got[31] == 0, "R9 pio error aborts", 32'(err_cnt - e0), 1);

        // Random transfers.
        for (int n = 0; n < 6; n++) begin
            run_xfer(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), $urandom_range(1, 1400));
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule